// File: doc/BRIEF.md
# Iterative Single-Precision Floating-Point Divider

This block divides one 32-bit IEEE 754 single-precision value, the dividend, by a second, the divisor. It works out one quotient mantissa bit per clock with a restoring shift-and-subtract loop. It then rounds to nearest, with ties going to the even value, and packs the result. The block always takes the same number of cycles, 67 from the load edge to the result, whatever the operands.

The handshake is a single load strobe and a busy flag. The caller drives both operands and raises `load` while `busy` is low. The block takes the operands on that rising edge and raises `busy`. When `busy` drops again, the quotient and its 3-bit status hold the answer, and the next operation may be loaded in that same cycle. Only one operation is in flight at a time.

Subnormal dividends and divisors are normalised before the loop runs. Results too small for the normal range come out as subnormals. Overflow, division by zero, infinities and NaN operands are resolved into signed infinities, signed zeros or a canonical NaN.

Top module: `fp32_div_iter`

## Requirements
- R1: Words use bit 31 for the sign, bits 30:23 for the biased exponent (bias 127) and bits 22:0 for the fraction. For finite normal operands the quotient is dividend/divisor rounded to nearest with ties to even (1/3 gives 0x3EAAAAAB, 6/2 gives 0x40400000).
- R2: A high `load` sampled on a rising edge while `busy` is low captures both operands, and `busy` is high after that edge.
- R3: `busy` stays high for exactly 67 clock cycles after the load edge. `quotient` and `status` do not change while `busy` is high and hold the new result once it falls.
- R4: A `load` pulse while `busy` is high is ignored. The running operation finishes with its own result and latency, and no second operation starts.
- R5: In `status`, bit 2 marks a NaN result, bit 1 an infinite result and bit 0 a subnormal result (exponent field 0, fraction nonzero). At most one bit is set, and a zero or normal result gives 0.
- R6: Subnormal dividends and divisors are treated by their exact value (0x00000001 / 0.5 gives 0x00000002; 1.0 / 0x00400000 gives 0x7F000000).
- R7: Quotients below the normal range are returned as subnormals with the same rounding. An exact half-ulp tie goes to even (0x00000003 / 2 gives 0x00000002, and 0x00000001 / 2 gives 0x00000000). A round-up may carry into the smallest normal (0x00FFFFFF / 2 gives 0x00800000, status 0).
- R8: Quotients whose magnitude exceeds the largest finite value give an infinity carrying the XOR of the operand signs, with status 3'b010.
- R9: A nonzero non-NaN dividend divided by zero, or an infinite dividend divided by a finite divisor, gives a signed infinity with status 3'b010.
- R10: 0/0, inf/inf and any NaN operand give 0x7FC00000 (all-ones exponent, fraction MSB set) with status 3'b100.
- R11: A finite dividend divided by infinity, and zero divided by a nonzero finite divisor, give a zero whose sign is the XOR of the operand signs, with status 0.
- R12: After reset, `busy` is low and `quotient` and `status` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Operand load strobe, active high |
| dividend | input | 32 | Left operand (numerator) |
| divisor | input | 32 | Right operand (denominator) |
| quotient | output | 32 | Result, valid while busy is low |
| busy | output | 1 | High while a division is in progress |
| status | output | 3 | Bit 2 NaN, bit 1 infinity, bit 0 subnormal result |

## Verification
Normal operands are chosen in two groups. Exact ratios such as 6/2 and -7.5/2.5 check the exponent arithmetic and the sign. Repeating ratios such as 1/3 and 2/3 exercise both the quotient-below-one exponent correction and round-up from the sticky remainder.

Subnormal inputs are divided by 0.5 and 2 and used as divisors. These cases separate the normalising shift on entry from the denormalising shift on exit, and they cover an exact tie, a tie that rounds to zero, and a round-up that carries into the smallest normal.

The special cases are tried one at a time: zero divisors, infinities, NaN and overflow. A load pulse is also sent mid-operation. This pulse tells apart a design that ignores it from one that restarts or clobbers the running result.

// File: rtl/fp32_div_pkg.sv
package fp32_div_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MANT_W = FRAC_W + 1;          // hidden bit + fraction
    localparam int QBITS  = FRAC_W + 4;          // 24 result bits + guard + extra
    localparam int REM_W  = MANT_W + 2;          // partial remainder < 4
    localparam int SEXP_W = EXP_W + 3;           // signed working exponent
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_FIN,
        CLS_INF,
        CLS_NAN
    } fcls_e;

    typedef enum logic [1:0] {
        SP_NONE,
        SP_NAN,
        SP_INF,
        SP_ZERO
    } spec_e;

    // position of the most significant set bit of a fraction field
    function automatic int lead_one(input logic [FRAC_W-1:0] f);
        int p;
        p = 0;
        for (int i = 0; i < FRAC_W; i++) begin
            if (f[i]) p = i;
        end
        return p;
    endfunction

endpackage

// File: rtl/fp_unpack.sv
module fp_unpack
    import fp32_div_pkg::*;
(
    input  logic [WORD_W-1:0]        word,
    output logic                     sign,
    output fcls_e                    cls,
    output logic [MANT_W-1:0]        mant,
    output logic signed [SEXP_W-1:0] bexp
);
    logic [EXP_W-1:0]  efld;
    logic [FRAC_W-1:0] ffld;
    int                pos;

    always_comb begin
        efld = word[WORD_W-2:FRAC_W];
        ffld = word[FRAC_W-1:0];
        sign = word[WORD_W-1];
        pos  = lead_one(ffld);
        mant = '0;
        bexp = '0;
        if (efld == '1) begin
            cls = (ffld != '0) ? CLS_NAN : CLS_INF;
        end else if (efld == '0) begin
            if (ffld == '0) begin
                cls = CLS_ZERO;
            end else begin
                // subnormal: move the leading one up to the hidden-bit slot
                cls  = CLS_FIN;
                mant = MANT_W'({1'b0, ffld} << (FRAC_W - pos));
                bexp = SEXP_W'(pos - (FRAC_W - 1));
            end
        end else begin
            cls  = CLS_FIN;
            mant = {1'b1, ffld};
            bexp = SEXP_W'({3'b000, efld});
        end
    end

endmodule

// File: rtl/fp_div_step.sv
module fp_div_step
    import fp32_div_pkg::*;
(
    input  logic [REM_W-1:0]  rem_i,
    input  logic [MANT_W-1:0] dvsr,
    output logic [REM_W-1:0]  rem_o,
    output logic              qbit
);
    logic [REM_W-1:0] dvsr_ext;
    logic [REM_W-1:0] keep;

    always_comb begin
        dvsr_ext = {2'b00, dvsr};
        qbit     = (rem_i >= dvsr_ext);
        keep     = qbit ? (rem_i - dvsr_ext) : rem_i;
        rem_o    = {keep[REM_W-2:0], 1'b0};
    end

endmodule

// File: rtl/fp_round_pack.sv
module fp_round_pack
    import fp32_div_pkg::*;
(
    input  logic                     sign,
    input  logic [QBITS-1:0]         qv,
    input  logic                     sticky_in,
    input  logic signed [SEXP_W-1:0] sexp,
    output logic [WORD_W-1:0]        word,
    output logic [2:0]               status
);
    localparam logic signed [SEXP_W-1:0] EMAX = SEXP_W'((1 << EXP_W) - 1);
    localparam logic signed [SEXP_W-1:0] SHMAX = SEXP_W'(QBITS + 1);

    logic [QBITS-1:0]            m;
    logic signed [SEXP_W-1:0]    e;
    logic signed [SEXP_W-1:0]    sh;
    logic [2*QBITS-1:0]          wide;
    logic [QBITS-1:0]            ms;
    logic                        lost;
    logic [EXP_W-1:0]            efld;
    logic [MANT_W-1:0]           keep;
    logic                        grd;
    logic                        stk;
    logic                        up;
    logic [EXP_W+FRAC_W-1:0]     body;

    always_comb begin
        // bring the leading one to the top bit
        if (qv[QBITS-1]) begin
            m = qv;
            e = sexp;
        end else begin
            m = {qv[QBITS-2:0], 1'b0};
            e = sexp - SEXP_W'(1);
        end

        sh   = '0;
        wide = '0;
        ms   = m;
        lost = 1'b0;
        efld = '0;
        if (e <= 0) begin
            sh = SEXP_W'(1) - e;
            if (sh > SHMAX) sh = SHMAX;
            wide = {m, {QBITS{1'b0}}} >> sh;
            ms   = wide[2*QBITS-1:QBITS];
            lost = |wide[QBITS-1:0];
        end else begin
            efld = e[EXP_W-1:0];
        end

        keep = ms[QBITS-1:QBITS-MANT_W];
        grd  = ms[QBITS-MANT_W-1];
        stk  = (|ms[QBITS-MANT_W-2:0]) | lost | sticky_in;
        up   = grd & (stk | keep[0]);
        // carry out of the fraction walks into the exponent field on its own
        body = {efld, keep[FRAC_W-1:0]} + (EXP_W + FRAC_W)'(up);

        if (e >= EMAX) begin
            word   = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            status = 3'b010;
        end else begin
            word = {sign, body};
            if (body[EXP_W+FRAC_W-1:FRAC_W] == '1)
                status = 3'b010;
            else if (body[EXP_W+FRAC_W-1:FRAC_W] == '0 && body[FRAC_W-1:0] != '0)
                status = 3'b001;
            else
                status = 3'b000;
        end
    end

endmodule

// File: rtl/fp32_div_iter.sv
module fp32_div_iter
    import fp32_div_pkg::*;
#(
    parameter int LATENCY = 67
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] dividend,
    input  logic [31:0] divisor,
    output logic [31:0] quotient,
    output logic        busy,
    output logic [2:0]  status
);
    localparam int CNT_W = $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LATENCY - 1);
    localparam logic [CNT_W-1:0] CNT_STEP = CNT_W'(QBITS);

    typedef struct packed {
        logic                     busy;
        logic [CNT_W-1:0]         cnt;
        logic [WORD_W-1:0]        opa;
        logic [WORD_W-1:0]        opb;
        logic                     sign;
        spec_e                    spec;
        logic signed [SEXP_W-1:0] exp;
        logic [REM_W-1:0]         rem;
        logic [MANT_W-1:0]        mb;
        logic [QBITS-1:0]         qacc;
        logic [WORD_W-1:0]        quo;
        logic [2:0]               stat;
    } state_t;

    state_t s_d, s_q;

    logic                     a_sign, b_sign;
    fcls_e                    a_cls, b_cls;
    logic [MANT_W-1:0]        a_mant, b_mant;
    logic signed [SEXP_W-1:0] a_exp, b_exp;
    logic [REM_W-1:0]         step_rem;
    logic                     step_bit;
    logic [WORD_W-1:0]        pk_word;
    logic [2:0]               pk_stat;

    fp_unpack i_unpack_a (
        .word(s_q.opa), .sign(a_sign), .cls(a_cls), .mant(a_mant), .bexp(a_exp)
    );

    fp_unpack i_unpack_b (
        .word(s_q.opb), .sign(b_sign), .cls(b_cls), .mant(b_mant), .bexp(b_exp)
    );

    fp_div_step i_step (
        .rem_i(s_q.rem), .dvsr(s_q.mb), .rem_o(step_rem), .qbit(step_bit)
    );

    fp_round_pack i_pack (
        .sign(s_q.sign), .qv(s_q.qacc), .sticky_in(s_q.rem != '0),
        .sexp(s_q.exp), .word(pk_word), .status(pk_stat)
    );

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (load) begin
                s_d.busy = 1'b1;
                s_d.cnt  = '0;
                s_d.opa  = dividend;
                s_d.opb  = divisor;
            end
        end else begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
            if (s_q.cnt == '0) begin
                // classify and prepare the mantissa loop
                s_d.sign = a_sign ^ b_sign;
                if (a_cls == CLS_NAN || b_cls == CLS_NAN ||
                    (a_cls == CLS_ZERO && b_cls == CLS_ZERO) ||
                    (a_cls == CLS_INF && b_cls == CLS_INF))
                    s_d.spec = SP_NAN;
                else if (a_cls == CLS_INF || b_cls == CLS_ZERO)
                    s_d.spec = SP_INF;
                else if (a_cls == CLS_ZERO || b_cls == CLS_INF)
                    s_d.spec = SP_ZERO;
                else
                    s_d.spec = SP_NONE;
                s_d.exp  = a_exp - b_exp + SEXP_W'(BIAS);
                s_d.rem  = {2'b00, a_mant};
                s_d.mb   = b_mant;
                s_d.qacc = '0;
            end else if (s_q.cnt <= CNT_STEP) begin
                s_d.rem  = step_rem;
                s_d.qacc = {s_q.qacc[QBITS-2:0], step_bit};
            end
            if (s_q.cnt == CNT_LAST) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
                case (s_q.spec)
                    SP_NAN: begin
                        s_d.quo  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
                        s_d.stat = 3'b100;
                    end
                    SP_INF: begin
                        s_d.quo  = {s_q.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                        s_d.stat = 3'b010;
                    end
                    SP_ZERO: begin
                        s_d.quo  = {s_q.sign, {(WORD_W-1){1'b0}}};
                        s_d.stat = 3'b000;
                    end
                    default: begin
                        s_d.quo  = pk_word;
                        s_d.stat = pk_stat;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign quotient = s_q.quo;
    assign busy     = s_q.busy;
    assign status   = s_q.stat;

    // R2: an accepted load starts an operation
    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy) |=> busy);

    // R3: busy only drops once the cycle counter has reached the end
    a_r3_fall_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(s_q.cnt) == CNT_LAST));

    // R3: result outputs frozen while an operation runs
    a_r3_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && s_q.cnt != CNT_LAST) |=> ($stable(quotient) && $stable(status)));

    // R4: operands are not replaced mid-operation
    a_r4_operands_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && s_q.cnt != CNT_LAST) |=> ($stable(s_q.opa) && $stable(s_q.opb)));

    // R5: at most one status flag
    a_r5_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status));

    // R10: NaN flag comes with a quiet NaN pattern
    a_r10_nan_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> (quotient[30:22] == 9'h1FF));

    // R8: infinity flag comes with an all-ones exponent and empty fraction
    a_r8_inf_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> (quotient[30:0] == 31'h7F800000));

endmodule

// File: tb/test_fp32_div_iter.sv
module test_fp32_div_iter;

    logic        clk;
    logic        rst_n;
    logic        load;
    logic [31:0] dividend;
    logic [31:0] divisor;
    logic [31:0] quotient;
    logic        busy;
    logic [2:0]  status;

    int n_checks = 0;
    int n_fail   = 0;

    fp32_div_iter i_fp32_div_iter (
        .clk(clk), .rst_n(rst_n), .load(load), .dividend(dividend),
        .divisor(divisor), .quotient(quotient), .busy(busy), .status(status)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one full operation; returns result, status, latency and busy after load edge
    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] q, output logic [2:0] st,
                          output int lat, output logic b0);
        @(negedge clk);
        dividend = a;
        divisor  = b;
        load     = 1'b1;
        @(negedge clk);
        load = 1'b0;
        b0   = busy;
        lat  = 0;
        while (busy) begin
            lat++;
            @(negedge clk);
        end
        q  = quotient;
        st = status;
    endtask

    task automatic div_case(input string tag, input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] exp_q, input logic [2:0] exp_st);
        logic [31:0] q;
        logic [2:0]  st;
        int          lat;
        logic        b0;
        run_op(a, b, q, st, lat, b0);
        check({tag, " quotient"}, q, exp_q);
        check({tag, " status"}, {29'd0, st}, {29'd0, exp_st});
    endtask

    task automatic t_reset;
        check("R12 busy after reset", {31'd0, busy}, 32'd0);
        check("R12 quotient after reset", quotient, 32'd0);
        check("R12 status after reset", {29'd0, status}, 32'd0);
    endtask

    task automatic t_handshake;
        logic [31:0] q;
        logic [2:0]  st;
        int          lat;
        logic        b0;
        run_op(32'h40C00000, 32'h40000000, q, st, lat, b0);
        check("R2 busy after load edge", {31'd0, b0}, 32'd1);
        check("R3 latency 67", lat, 67);
        check("R3 result 6/2", q, 32'h40400000);
    endtask

    task automatic t_normal;
        div_case("R1 1/3", 32'h3F800000, 32'h40400000, 32'h3EAAAAAB, 3'b000);
        div_case("R1 2/3", 32'h40000000, 32'h40400000, 32'h3F2AAAAB, 3'b000);
        div_case("R1 -7.5/2.5", 32'hC0F00000, 32'h40200000, 32'hC0400000, 3'b000);
    endtask

    task automatic t_ignore_load;
        int lat;
        @(negedge clk);
        dividend = 32'h40C00000;
        divisor  = 32'h40000000;
        load     = 1'b1;
        @(negedge clk);
        load = 1'b0;
        lat  = 0;
        while (busy) begin
            lat++;
            if (lat == 10) begin
                dividend = 32'h3F800000;
                divisor  = 32'h00000000;
                load     = 1'b1;
            end else begin
                load = 1'b0;
            end
            @(negedge clk);
        end
        load = 1'b0;
        check("R4 latency unchanged", lat, 67);
        check("R4 result of first op", quotient, 32'h40400000);
        repeat (3) @(negedge clk);
        check("R4 no second op started", {31'd0, busy}, 32'd0);
        check("R4 result held", quotient, 32'h40400000);
    endtask

    task automatic t_subnormal;
        div_case("R6 min sub/0.5", 32'h00000001, 32'h3F000000, 32'h00000002, 3'b001);
        div_case("R6 1/sub divisor", 32'h3F800000, 32'h00400000, 32'h7F000000, 3'b000);
        div_case("R7 min normal/2", 32'h00800000, 32'h40000000, 32'h00400000, 3'b001);
        div_case("R7 tie to even", 32'h00000003, 32'h40000000, 32'h00000002, 3'b001);
        div_case("R7 tie to zero", 32'h00000001, 32'h40000000, 32'h00000000, 3'b000);
        div_case("R7 carry to normal", 32'h00FFFFFF, 32'h40000000, 32'h00800000, 3'b000);
    endtask

    task automatic t_special;
        div_case("R8 overflow", 32'h7F7FFFFF, 32'h3F000000, 32'h7F800000, 3'b010);
        div_case("R8 neg overflow", 32'hFF7FFFFF, 32'h3F000000, 32'hFF800000, 3'b010);
        div_case("R9 1/0", 32'h3F800000, 32'h00000000, 32'h7F800000, 3'b010);
        div_case("R9 -1/0", 32'hBF800000, 32'h00000000, 32'hFF800000, 3'b010);
        div_case("R9 inf/2", 32'h7F800000, 32'h40000000, 32'h7F800000, 3'b010);
        div_case("R10 0/0", 32'h00000000, 32'h80000000, 32'h7FC00000, 3'b100);
        div_case("R10 inf/inf", 32'h7F800000, 32'hFF800000, 32'h7FC00000, 3'b100);
        div_case("R10 NaN/1", 32'h7FC12345, 32'h3F800000, 32'h7FC00000, 3'b100);
        div_case("R11 5/inf", 32'h40A00000, 32'h7F800000, 32'h00000000, 3'b000);
        div_case("R11 -5/inf", 32'hC0A00000, 32'h7F800000, 32'h80000000, 3'b000);
        div_case("R11 0/-5", 32'h00000000, 32'hC0A00000, 32'h80000000, 3'b000);
    endtask

    initial begin
        rst_n    = 1'b0;
        load     = 1'b0;
        dividend = '0;
        divisor  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_normal();
        t_ignore_load();
        t_subnormal();
        t_special();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule